// File: doc/BRIEF.md
# Square Wave Tone Channel

This block is one tone voice of a small sound unit. It makes a pulse wave whose period is set by an 11-bit rate and whose high time is one of four fixed fractions. It scales the pulse by a 4-bit volume that a slow envelope can ramp up or down. It can also stop itself after a programmed length. The result is a 4-bit amplitude sample on every clock, along with a flag that says whether the voice is sounding.

Software drives the channel through three write-only words, picked by `wr_sel`:

- **Select 0: master word.** This is a global enable. While its bit 7 is clear, writes to the two channel words are dropped.
- **Select 1: shape word.** It carries the length, the duty code and the envelope settings.
- **Select 2: pitch word.** It carries the rate, the timed-mode flag and the restart strobe.
- **Select 3.** No register; a write here has no effect.

An internal prescaler turns the system clock into three timing pulses:

- a base tick every `BASE_DIV` clocks, standing for 131072 Hz;
- a length tick every `LEN_DIV` base ticks, standing for 256 Hz;
- an envelope tick every `ENV_MUL` length ticks, standing for 64 Hz.

Top module: `square_tone_channel`

## Requirements
- R1: After reset `sample` is 0, `playing` is 0 and the master enable is off.
- R2: While bit 7 of the master word (select 0) is 0, writes to select 1 and select 2 change nothing, a restart strobe included, so the output keeps its previous waveform.
- R3: Bits 7:6 of the shape word select the high steps of the 8-step wave cycle. The step index is 0 after a restart. Code 0 is high at step 7 only (1/8). Code 1 is high at steps 6-7 (2/8). Code 2 is high at steps 4-7 (4/8). Code 3 is high at steps 2-7 (6/8).
- R4: Each wave step lasts (2048 - rate) base ticks, where rate is bits 10:0 of the pitch word. A full cycle therefore lasts 8*(2048-rate)*BASE_DIV clocks.
- R5: Writing the pitch word with bit 15 set does four things: it sets `playing`, loads the volume from bits 15:12 of the shape word, sets the step index to 0 and reloads the step timer.
- R6: `sample` equals the current volume while `playing` is 1 and the step is high, and is 0 otherwise.
- R7: With bit 14 of the pitch word set, the channel stops (`playing` falls) once its length count reaches zero.
  - The count starts at 64 - n, where n is bits 5:0 of the shape word, and loses one on each length tick.
  - A restart reloads the count only when it is zero.
  - With bit 14 clear, the channel plays indefinitely.
- R8: With a step time s (bits 10:8 of the shape word) other than 0, the volume moves by one every s envelope ticks. Bit 11 gives the direction: 1 means up. The volume saturates at 15 and at 0, and `playing` stays 1 at volume 0.
- R9: A step time of 0 holds the volume constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Target: 0 master, 1 shape, 2 pitch, 3 none |
| wr_data | input | 16 | Write data |
| sample | output | 4 | Amplitude sample |
| playing | output | 1 | Channel is active |

## Verification
The checker assumes that `wr_sel` is 3 only with no intended effect. It also assumes that the rate never makes the step timer reload from zero, so every base tick either decrements the timer or moves the step forward. Each write the bench issues is a single-cycle `wr_en` pulse driven away from the clock edge. The random cases keep the rate between 2040 and 2047 and the step time at 0. That way each measured cycle is short and the volume cannot drift while the high-step count and amplitude are being measured.

// File: rtl/square_tone_channel.sv
module square_tone_channel #(
  parameter int BASE_DIV = 2,
  parameter int LEN_DIV  = 512,
  parameter int ENV_MUL  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic [3:0]  sample,
  output logic        playing
);
  localparam int PW = $clog2(BASE_DIV + 1);
  localparam int LW = $clog2(LEN_DIV + 1);
  localparam int EW = $clog2(ENV_MUL + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(BASE_DIV - 1);
  localparam logic [LW-1:0] LEN_LAST = LW'(LEN_DIV - 1);
  localparam logic [EW-1:0] ENV_LAST = EW'(ENV_MUL - 1);

  logic [PW-1:0] pre;
  logic [LW-1:0] ldiv;
  logic [EW-1:0] ediv;
  logic base_tick, len_tick, env_tick;

  logic        master;
  logic [5:0]  len_n;
  logic [1:0]  duty;
  logic [2:0]  step;
  logic        up;
  logic [3:0]  init_vol;
  logic [10:0] rate;
  logic        timed;

  logic [6:0]  lcnt;
  logic [2:0]  ecnt;
  logic [3:0]  vol;
  logic [11:0] timer;
  logic [2:0]  phase;
  logic        high;

  logic wr_ok, wr_a, wr_b, restart;

  assign base_tick = (pre == PRE_LAST);
  assign len_tick  = base_tick && (ldiv == LEN_LAST);
  assign env_tick  = len_tick && (ediv == ENV_LAST);

  assign wr_ok   = wr_en && master;
  assign wr_a    = wr_ok && (wr_sel == 2'd1);
  assign wr_b    = wr_ok && (wr_sel == 2'd2);
  assign restart = wr_b && wr_data[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      ldiv <= '0;
      ediv <= '0;
    end else begin
      pre <= base_tick ? '0 : pre + 1'b1;
      if (base_tick) ldiv <= (ldiv == LEN_LAST) ? '0 : ldiv + 1'b1;
      if (len_tick)  ediv <= (ediv == ENV_LAST) ? '0 : ediv + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master   <= 1'b0;
      len_n    <= '0;
      duty     <= '0;
      step     <= '0;
      up       <= 1'b0;
      init_vol <= '0;
      rate     <= '0;
      timed    <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd0) master <= wr_data[7];
      if (wr_a) begin
        len_n    <= wr_data[5:0];
        duty     <= wr_data[7:6];
        step     <= wr_data[10:8];
        up       <= wr_data[11];
        init_vol <= wr_data[15:12];
      end
      if (wr_b) begin
        rate  <= wr_data[10:0];
        timed <= wr_data[14];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt    <= '0;
      playing <= 1'b0;
    end else if (wr_a) begin
      lcnt <= 7'd64 - {1'b0, wr_data[5:0]};
    end else if (restart) begin
      playing <= 1'b1;
      if (lcnt == 7'd0) lcnt <= 7'd64 - {1'b0, len_n};
    end else if (len_tick && playing && timed && lcnt != 7'd0) begin
      lcnt <= lcnt - 1'b1;
      if (lcnt == 7'd1) playing <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol  <= '0;
      ecnt <= '0;
    end else if (restart) begin
      vol  <= init_vol;
      ecnt <= '0;
    end else if (env_tick && playing && step != 3'd0) begin
      if (ecnt == step - 3'd1) begin
        ecnt <= '0;
        if (up && vol != 4'd15)      vol <= vol + 1'b1;
        else if (!up && vol != 4'd0) vol <= vol - 1'b1;
      end else begin
        ecnt <= ecnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      phase <= '0;
    end else if (restart) begin
      timer <= 12'd2048 - {1'b0, wr_data[10:0]};
      phase <= '0;
    end else if (base_tick) begin
      if (timer <= 12'd1) begin
        timer <= 12'd2048 - {1'b0, rate};
        phase <= phase + 1'b1;
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

  always_comb begin
    case (duty)
      2'd0:    high = (phase == 3'd7);
      2'd1:    high = (phase[2:1] == 2'b11);
      2'd2:    high = phase[2];
      default: high = phase[2] | phase[1];
    endcase
  end

  assign sample = (playing && high) ? vol : 4'd0;
endmodule

module square_tone_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic        master,
  input logic        restart,
  input logic        base_tick,
  input logic        env_tick,
  input logic        playing,
  input logic        timed,
  input logic [3:0]  sample,
  input logic [3:0]  vol,
  input logic [3:0]  init_vol,
  input logic [1:0]  duty,
  input logic [10:0] rate,
  input logic [2:0]  step,
  input logic [2:0]  phase
);
  p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !playing |-> sample == 4'd0);

  p_amp_is_vol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample != 4'd0 |-> sample == vol);

  p_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !master && wr_sel != 2'd0) |=> $stable({duty, init_vol, rate, timed, step}));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (playing && vol == $past(init_vol) && phase == 3'd0));

  p_phase_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !restart) |=> $stable(phase));

  p_vol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (step == 3'd0 || !env_tick)) |=> $stable(vol));

  p_stop_timed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(playing) |-> $past(timed));
endmodule

bind square_tone_channel square_tone_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .master(master),
  .restart(restart), .base_tick(base_tick), .env_tick(env_tick),
  .playing(playing), .timed(timed), .sample(sample), .vol(vol),
  .init_vol(init_vol), .duty(duty), .rate(rate), .step(step), .phase(phase)
);

// File: tb/tb_square_tone_channel.sv
module tb_square_tone_channel;
  localparam int BD = 2;
  localparam int LD = 512;
  localparam int EM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] sample;
  logic playing;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  square_tone_channel #(.BASE_DIV(BD), .LEN_DIV(LD), .ENV_MUL(EM)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sample(sample), .playing(playing)
  );

  function automatic int high_steps(input int d);
    case (d)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [15:0] shape(input int vol, input bit up, input int st,
                                        input int d, input int n);
    return {vol[3:0], up, st[2:0], d[1:0], n[5:0]};
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic measure(input int p, output int hi, output int mx, output int rises);
    logic prev;
    hi = 0; mx = 0; rises = 0;
    @(negedge clk);
    prev = (sample != 0);
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (sample != 0) hi++;
      if (int'(sample) > mx) mx = int'(sample);
      if (sample != 0 && !prev) rises++;
      prev = (sample != 0);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tone_case(input string req, input int d, input int v, input int rate);
    int hi, mx, rs, n, p;
    n = 2048 - rate;
    p = 8 * n * BD;
    wr(2'd1, shape(v, 1'b0, 0, d, 0));
    wr(2'd2, 16'h8000 | 16'(rate));
    wait_clks(20);
    measure(p, hi, mx, rs);
    check({req, " high count"}, hi, high_steps(d) * n * BD);
    check({req, " amplitude"}, mx, v);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int hi, mx, rs;
    void'($urandom(32'd2024));
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(2);
    check("R1 sample", int'(sample), 0);
    check("R1 playing", int'(playing), 0);

    wr(2'd1, shape(9, 1'b0, 0, 3, 0));
    wr(2'd2, 16'h8000 | 16'd2040);
    wait_clks(10);
    check("R2 restart ignored while master off", int'(playing), 0);

    wr(2'd0, 16'h0080);
    for (int d = 0; d < 4; d++) tone_case("R3 duty", d, 9, 2040);
    check("R5 playing after restart", int'(playing), 1);

    wr(2'd1, shape(11, 1'b0, 0, 2, 0));
    wr(2'd2, 16'h8000 | 16'd2044);
    wait_clks(20);
    measure(4 * 8 * 4 * BD, hi, mx, rs);
    check("R4 cycles in four periods", rs, 4);
    check("R6 amplitude", mx, 11);

    for (int k = 0; k < 8; k++) begin
      int d, v, r;
      d = int'($urandom_range(3, 0));
      v = int'($urandom_range(15, 1));
      r = int'($urandom_range(2047, 2040));
      tone_case("R3 R4 R6 random", d, v, r);
    end

    tone_case("R6 setup", 2, 9, 2040);
    wr(2'd0, 16'h0000);
    wr(2'd1, shape(3, 1'b0, 0, 0, 0));
    wr(2'd2, 16'h8000 | 16'd2046);
    wait_clks(20);
    measure(128, hi, mx, rs);
    check("R2 high count unchanged", hi, 4 * 8 * BD);
    check("R2 amplitude unchanged", mx, 9);
    wr(2'd0, 16'h0080);

    wr(2'd1, shape(5, 1'b0, 0, 3, 62));
    wr(2'd2, 16'hC000 | 16'd2040);
    wait_clks(1000);
    check("R7 still playing before two ticks", int'(playing), 1);
    wait_clks(1200);
    check("R7 timed stop", int'(playing), 0);
    check("R6 silent when stopped", int'(sample), 0);
    wr(2'd2, 16'hC000 | 16'd2040);
    wait_clks(5);
    check("R5 restart after expiry", int'(playing), 1);
    wait_clks(2200);
    check("R7 reloaded length expires", int'(playing), 0);
    wr(2'd2, 16'h8000 | 16'd2040);
    wait_clks(3000);
    check("R7 untimed keeps playing", int'(playing), 1);

    wr(2'd1, shape(13, 1'b1, 1, 3, 0));
    wr(2'd2, 16'h8000 | 16'd2040);
    wait_clks(3 * LD * EM * BD + 100);
    measure(128, hi, mx, rs);
    check("R8 rises and saturates at 15", mx, 15);

    wr(2'd1, shape(2, 1'b0, 1, 3, 0));
    wr(2'd2, 16'h8000 | 16'd2040);
    wait_clks(3 * LD * EM * BD + 100);
    measure(128, hi, mx, rs);
    check("R8 falls to 0", mx, 0);
    check("R8 playing at volume 0", int'(playing), 1);

    wr(2'd1, shape(7, 1'b1, 0, 3, 0));
    wr(2'd2, 16'h8000 | 16'd2040);
    wait_clks(2 * LD * EM * BD + 100);
    measure(128, hi, mx, rs);
    check("R9 step 0 holds volume", mx, 7);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule